// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the pointers and configuration for four descriptor rings of a DMA network port: the receive fill ring, the receive completion ring, the transmit request ring and the transmit completion ring. Each ring lives in memory as an array of 32-byte descriptors. Software owns one pointer of each ring and a hardware DMA engine owns the other. On the receive fill ring and the transmit request ring, software produces entries and the engine consumes them. On the receive completion ring and the transmit completion ring, the engine produces entries and software consumes them.

Software programs each ring's base address and size through a small register port and moves its own pointer there. The engine asks to step its own pointer with a one-cycle request. The block accepts the request only when that ring's gate bit is on and the ring has an entry to consume, or room to produce into. For every ring the block drives the engine's current descriptor address, the number of occupied entries, and empty and full flags. The descriptor and packet-data transfers themselves are outside this block.

Top module: `desc_ring_ptr_mgr`

## Requirements
- R1: After reset, all base addresses, depths, pointers, per-ring write-permit bits and the gate register read as zero. Every ring reports empty and not full, and no request is accepted.
- R2: Register address `cfg_addr[4:3]` selects the ring (0 receive fill, 1 receive completion, 2 transmit request, 3 transmit completion) and `cfg_addr[2:0]` selects the register (0 base, 1 depth, 2 write pointer, 3 read pointer, 4 permit, 7 gate). A base write is taken only while permit bit 2 of that ring is set. A depth write is taken only while permit bit 1 is set. Otherwise the write is ignored.
- R3: The depth register holds the descriptor count shifted left by 3 (count in bits [9:3]). Pointers read back as byte offsets equal to the index times 32 (index in bits [11:5]). Register codes 5 and 6 read as zero.
- R4: Software writes only its own pointer: the write pointer of rings 0 and 2 and the read pointer of rings 1 and 3. A write to the engine-owned pointer is ignored.
- R5: An accepted engine step increments the engine's index. The index wraps to 0 when the increment equals the programmed depth. A ring of depth 0 accepts no step.
- R6: Gate register bits map to rings as follows: bit 2 to ring 0, bit 3 to ring 1, bit 0 to ring 2 and bit 1 to ring 3. A request on a ring whose gate bit is clear is not accepted (`hw_take` low, pointer unchanged).
- R7: A ring is full when the write index, stepped once, equals the read index, so one slot always stays unused. On an engine-consumer ring (0, 2), a request while empty is ignored. On an engine-producer ring (1, 3), a request while full is ignored.
- R8: `hw_desc_addr` of a ring equals its base address plus the engine-owned index times 32.
- R9: `hw_empty` is set when the write and read indices are equal. `hw_level` equals write minus read when write is at or past read, and depth minus read plus write otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Ring select [4:3] and register select [2:0] |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the register at `cfg_addr` (combinational) |
| hw_adv | input | 4 | Per-ring engine step request, one bit per ring |
| hw_take | output | 4 | Per-ring request accepted this cycle |
| hw_empty | output | 4 | Per-ring empty flag |
| hw_full | output | 4 | Per-ring full flag |
| hw_level | output | 4*IDX_W | Per-ring occupied entry count, ring 0 in the low slice |
| hw_desc_addr | output | 4*ADDR_W | Per-ring engine descriptor address, ring 0 in the low slice |

## Verification
The accept flag `hw_take` is combinational from the request and the current state, so it is due in the same cycle the request is presented. The bench samples it one time unit after driving inputs at the falling edge. Register writes and accepted steps land at the next rising edge, and every flag, level, address and read-back value follows combinationally from the registers. The bench therefore samples these one time unit after that rising edge and compares them with its own ring model, which it updates at the same point. Read-back of `cfg_rdata` is combinational on `cfg_addr`, so it is checked in the same sampling slot as the state outputs.

// File: rtl/drpm_pkg.sv
package drpm_pkg;

    localparam int NUM_RINGS   = 4;
    localparam int DESC_SHIFT  = 5;
    localparam int DEPTH_SHIFT = 3;

    typedef enum logic [2:0] {
        REG_BASE   = 3'd0,
        REG_DEPTH  = 3'd1,
        REG_WPTR   = 3'd2,
        REG_RPTR   = 3'd3,
        REG_PERMIT = 3'd4,
        REG_GATE   = 3'd7
    } reg_code_e;

    typedef enum logic [1:0] {
        RING_RX_FILL = 2'd0,
        RING_RX_DONE = 2'd1,
        RING_TX_REQ  = 2'd2,
        RING_TX_DONE = 2'd3
    } ring_id_e;

    // Rings where the engine moves the write pointer
    function automatic bit engine_produces(int ring);
        return (ring == 1) || (ring == 3);
    endfunction

    // Gate register bit that controls each ring
    function automatic int gate_bit_of(int ring);
        case (ring)
            0:       return 2;
            1:       return 3;
            2:       return 0;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/drpm_ring.sv
module drpm_ring #(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 7,
    parameter bit HW_PRODUCER = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_reg,
    input  logic [31:0]       wr_data,
    input  logic              gate_on,
    input  logic              adv_req,
    output logic [ADDR_W-1:0] base_q,
    output logic [IDX_W-1:0]  depth_q,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [1:0]        permit_q,
    output logic              adv_take,
    output logic              empty,
    output logic              full,
    output logic [IDX_W-1:0]  level,
    output logic [ADDR_W-1:0] desc_addr
);
    import drpm_pkg::*;

    localparam int OFF_W = IDX_W + DESC_SHIFT;

    logic [IDX_W-1:0] hw_idx;
    logic [IDX_W:0]   hw_inc;
    logic [IDX_W-1:0] hw_next;
    logic [IDX_W:0]   wr_inc;
    logic [IDX_W-1:0] wr_next;
    logic             room;
    logic [ADDR_W-1:0] offset;

    assign hw_idx = HW_PRODUCER ? wr_idx : rd_idx;

    always_comb begin
        hw_inc  = {1'b0, hw_idx} + 1'b1;
        hw_next = (hw_inc == {1'b0, depth_q}) ? '0 : hw_inc[IDX_W-1:0];
        wr_inc  = {1'b0, wr_idx} + 1'b1;
        wr_next = (wr_inc == {1'b0, depth_q}) ? '0 : wr_inc[IDX_W-1:0];
    end

    assign empty    = (wr_idx == rd_idx);
    assign full     = (wr_next == rd_idx);
    assign room     = HW_PRODUCER ? !full : !empty;
    assign adv_take = adv_req && gate_on && (depth_q != '0) && room;

    always_comb begin
        if (wr_idx >= rd_idx) level = wr_idx - rd_idx;
        else                  level = depth_q - rd_idx + wr_idx;
    end

    always_comb begin
        offset = '0;
        offset[OFF_W-1:0] = {hw_idx, {DESC_SHIFT{1'b0}}};
    end
    assign desc_addr = base_q + offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            depth_q  <= '0;
            wr_idx   <= '0;
            rd_idx   <= '0;
            permit_q <= '0;
        end else begin
            if (wr_en) begin
                case (wr_reg)
                    REG_BASE:   if (permit_q[1]) base_q <= wr_data[ADDR_W-1:0];
                    REG_DEPTH:  if (permit_q[0]) depth_q <= wr_data[IDX_W+DEPTH_SHIFT-1:DEPTH_SHIFT];
                    REG_WPTR:   if (!HW_PRODUCER) wr_idx <= wr_data[OFF_W-1:DESC_SHIFT];
                    REG_RPTR:   if (HW_PRODUCER) rd_idx <= wr_data[OFF_W-1:DESC_SHIFT];
                    REG_PERMIT: permit_q <= wr_data[2:1];
                    default:    ;
                endcase
            end
            if (adv_take) begin
                if (HW_PRODUCER) wr_idx <= hw_next;
                else             rd_idx <= hw_next;
            end
        end
    end

endmodule

// File: rtl/drpm_gate.sv
module drpm_gate #(
    parameter int NQ = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [NQ-1:0] wr_data,
    output logic [NQ-1:0] gate_q
);
    always_ff @(posedge clk) begin
        if (rst)        gate_q <= '0;
        else if (wr_en) gate_q <= wr_data;
    end
endmodule

// File: rtl/drpm_rdmux.sv
module drpm_rdmux #(
    parameter int NQ     = 4,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7
) (
    input  logic [1:0]                 sel_ring,
    input  logic [2:0]                 sel_reg,
    input  logic [NQ-1:0][ADDR_W-1:0]  base_all,
    input  logic [NQ-1:0][IDX_W-1:0]   depth_all,
    input  logic [NQ-1:0][IDX_W-1:0]   wr_all,
    input  logic [NQ-1:0][IDX_W-1:0]   rd_all,
    input  logic [NQ-1:0][1:0]         permit_all,
    input  logic [NQ-1:0]              gate,
    output logic [31:0]                rdata
);
    import drpm_pkg::*;

    always_comb begin
        rdata = '0;
        case (sel_reg)
            REG_BASE:   rdata[ADDR_W-1:0] = base_all[sel_ring];
            REG_DEPTH:  rdata[IDX_W+DEPTH_SHIFT-1:0] = {depth_all[sel_ring], {DEPTH_SHIFT{1'b0}}};
            REG_WPTR:   rdata[IDX_W+DESC_SHIFT-1:0] = {wr_all[sel_ring], {DESC_SHIFT{1'b0}}};
            REG_RPTR:   rdata[IDX_W+DESC_SHIFT-1:0] = {rd_all[sel_ring], {DESC_SHIFT{1'b0}}};
            REG_PERMIT: rdata[2:0] = {permit_all[sel_ring], 1'b0};
            REG_GATE:   rdata[NQ-1:0] = gate;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/desc_ring_ptr_mgr.sv
module desc_ring_ptr_mgr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [4:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic [3:0]            hw_adv,
    output logic [3:0]            hw_take,
    output logic [3:0]            hw_empty,
    output logic [3:0]            hw_full,
    output logic [4*IDX_W-1:0]    hw_level,
    output logic [4*ADDR_W-1:0]   hw_desc_addr
);
    import drpm_pkg::*;

    localparam int NQ = NUM_RINGS;

    logic [1:0] sel_ring;
    logic [2:0] sel_reg;
    logic       gate_wr;
    logic [NQ-1:0] gate_q;

    logic [NQ-1:0][ADDR_W-1:0] base_all;
    logic [NQ-1:0][IDX_W-1:0]  depth_all;
    logic [NQ-1:0][IDX_W-1:0]  wr_all;
    logic [NQ-1:0][IDX_W-1:0]  rd_all;
    logic [NQ-1:0][1:0]        permit_all;

    assign sel_ring = cfg_addr[4:3];
    assign sel_reg  = cfg_addr[2:0];
    assign gate_wr  = cfg_we && (sel_reg == REG_GATE);

    drpm_gate #(.NQ(NQ)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (gate_wr),
        .wr_data (cfg_wdata[NQ-1:0]),
        .gate_q  (gate_q)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_ring
        localparam bit PROD = engine_produces(q);
        localparam int GB   = gate_bit_of(q);
        logic ring_wr;
        assign ring_wr = cfg_we && (sel_ring == q[1:0]) && (sel_reg != REG_GATE);

        drpm_ring #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HW_PRODUCER(PROD)) u_ring (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (ring_wr),
            .wr_reg    (sel_reg),
            .wr_data   (cfg_wdata),
            .gate_on   (gate_q[GB]),
            .adv_req   (hw_adv[q]),
            .base_q    (base_all[q]),
            .depth_q   (depth_all[q]),
            .wr_idx    (wr_all[q]),
            .rd_idx    (rd_all[q]),
            .permit_q  (permit_all[q]),
            .adv_take  (hw_take[q]),
            .empty     (hw_empty[q]),
            .full      (hw_full[q]),
            .level     (hw_level[q*IDX_W +: IDX_W]),
            .desc_addr (hw_desc_addr[q*ADDR_W +: ADDR_W])
        );
    end

    drpm_rdmux #(.NQ(NQ), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rdmux (
        .sel_ring   (sel_ring),
        .sel_reg    (sel_reg),
        .base_all   (base_all),
        .depth_all  (depth_all),
        .wr_all     (wr_all),
        .rd_all     (rd_all),
        .permit_all (permit_all),
        .gate       (gate_q),
        .rdata      (cfg_rdata)
    );

endmodule

// File: rtl/drpm_chk.sv
module drpm_chk #(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic [3:0]          hw_adv,
    input logic [3:0]          hw_take,
    input logic [3:0]          hw_empty,
    input logic [3:0]          hw_full,
    input logic [3:0]          gate_q,
    input logic [4*ADDR_W-1:0] hw_desc_addr
);
    import drpm_pkg::*;

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    always_ff @(posedge clk) begin
        // R1
        if (rst_seen && !rst) reset_empty_chk: assert (hw_empty == 4'hF && hw_take == 4'h0);
    end

    for (genvar q = 0; q < 4; q++) begin : g_q
        localparam int  GB   = gate_bit_of(q);
        localparam bit  PROD = engine_produces(q);

        // R6
        take_needs_gate_chk: assert property (@(posedge clk) disable iff (rst)
            hw_take[q] |-> (gate_q[GB] && hw_adv[q]));

        // R7
        take_needs_room_chk: assert property (@(posedge clk) disable iff (rst)
            hw_take[q] |-> (PROD ? !hw_full[q] : !hw_empty[q]));

        // R8
        addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!hw_adv[q] && !cfg_we) |=> $stable(hw_desc_addr[q*ADDR_W +: ADDR_W]));
    end
endmodule

bind desc_ring_ptr_mgr drpm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .hw_adv       (hw_adv),
    .hw_take      (hw_take),
    .hw_empty     (hw_empty),
    .hw_full      (hw_full),
    .gate_q       (gate_q),
    .hw_desc_addr (hw_desc_addr)
);

// File: tb/desc_ring_ptr_mgr_tb.sv
module desc_ring_ptr_mgr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int IW = 7;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we;
    logic [4:0] cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [3:0] hw_adv, hw_take, hw_empty, hw_full;
    logic [4*IW-1:0] hw_level;
    logic [4*AW-1:0] hw_desc_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_base [4];
    logic [IW-1:0] m_dep [4];
    logic [IW-1:0] m_wi [4];
    logic [IW-1:0] m_ri [4];
    logic [1:0] m_perm [4];
    logic [3:0] m_gate;
    int gbit [4] = '{2, 3, 0, 1};
    bit prod [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_ring_ptr_mgr #(.ADDR_W(AW), .IDX_W(IW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_adv(hw_adv),
        .hw_take(hw_take), .hw_empty(hw_empty), .hw_full(hw_full),
        .hw_level(hw_level), .hw_desc_addr(hw_desc_addr)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] nx(logic [IW-1:0] i, logic [IW-1:0] d);
        logic [IW:0] s;
        s = {1'b0, i} + 1'b1;
        return (s == {1'b0, d}) ? '0 : s[IW-1:0];
    endfunction

    function automatic logic [IW-1:0] lvl(int q);
        if (m_wi[q] >= m_ri[q]) return m_wi[q] - m_ri[q];
        return m_dep[q] - m_ri[q] + m_wi[q];
    endfunction

    function automatic bit exp_take(int q, logic [3:0] adv);
        bit roomy;
        roomy = prod[q] ? (nx(m_wi[q], m_dep[q]) != m_ri[q]) : (m_wi[q] != m_ri[q]);
        return adv[q] && m_gate[gbit[q]] && (m_dep[q] != 0) && roomy;
    endfunction

    function automatic logic [31:0] exp_rd(logic [4:0] a);
        int q = int'(a[4:3]);
        case (a[2:0])
            3'd0: return m_base[q];
            3'd1: return {22'd0, m_dep[q], 3'b0};
            3'd2: return {20'd0, m_wi[q], 5'b0};
            3'd3: return {20'd0, m_ri[q], 5'b0};
            3'd4: return {29'd0, m_perm[q], 1'b0};
            3'd7: return {28'd0, m_gate};
            default: return 32'd0;
        endcase
    endfunction

    task automatic compare_state();
        for (int q = 0; q < 4; q++) begin
            logic [IW-1:0] hi;
            hi = prod[q] ? m_wi[q] : m_ri[q];
            chk("R9", "empty", 64'(hw_empty[q]), 64'(m_wi[q] == m_ri[q]));
            chk("R7", "full", 64'(hw_full[q]), 64'(nx(m_wi[q], m_dep[q]) == m_ri[q]));
            chk("R9", "level", 64'(hw_level[q*IW +: IW]), 64'(lvl(q)));
            chk("R8", "desc_addr", 64'(hw_desc_addr[q*AW +: AW]),
                64'(m_base[q] + {20'd0, hi, 5'b0}));
        end
        chk("R3", "rdata", 64'(cfg_rdata), 64'(exp_rd(cfg_addr)));
    endtask

    task automatic step(bit we, logic [4:0] a, logic [31:0] d, logic [3:0] adv);
        bit tk [4];
        int q;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; hw_adv = adv;
        #1;
        for (int i = 0; i < 4; i++) begin
            tk[i] = exp_take(i, adv);
            chk("R6", "take", 64'(hw_take[i]), 64'(tk[i]));
        end
        @(posedge clk);
        #1;
        if (we) begin
            q = int'(a[4:3]);
            case (a[2:0])
                3'd0: if (m_perm[q][1]) m_base[q] = d;
                3'd1: if (m_perm[q][0]) m_dep[q] = d[IW+2:3];
                3'd2: if (!prod[q]) m_wi[q] = d[IW+4:5];
                3'd3: if (prod[q]) m_ri[q] = d[IW+4:5];
                3'd4: m_perm[q] = d[2:1];
                3'd7: m_gate = d[3:0];
                default: ;
            endcase
        end
        for (int i = 0; i < 4; i++)
            if (tk[i]) begin
                if (prod[i]) m_wi[i] = nx(m_wi[i], m_dep[i]);
                else         m_ri[i] = nx(m_ri[i], m_dep[i]);
            end
        compare_state();
        cfg_we = 1'b0;
    endtask

    task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = a; hw_adv = '0;
        #1;
        chk(req, "readback", 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic wr(logic [1:0] q, logic [2:0] r, logic [31:0] d);
        step(1'b1, {q, r}, d, 4'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4177));
        for (int q = 0; q < 4; q++) begin
            m_base[q] = '0; m_dep[q] = '0; m_wi[q] = '0; m_ri[q] = '0; m_perm[q] = '0;
        end
        m_gate = '0;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; hw_adv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1", "empty", 64'(hw_empty), 64'hF);
        chk("R1", "full", 64'(hw_full), 64'h0);
        for (int q = 0; q < 4; q++)
            for (int r = 0; r < 8; r++) rd("R1", {q[1:0], r[2:0]}, 32'd0);

        // R2 base and depth writes need their permit bits
        wr(2'd0, 3'd0, 32'h1000_0000);
        rd("R2", {2'd0, 3'd0}, 32'd0);
        wr(2'd0, 3'd4, 32'h2);
        wr(2'd0, 3'd0, 32'h1000_0000);
        rd("R2", {2'd0, 3'd0}, 32'd0);
        wr(2'd0, 3'd1, 32'd64 << 3);
        rd("R2", {2'd0, 3'd1}, 32'h200);
        wr(2'd0, 3'd4, 32'h4);
        wr(2'd0, 3'd1, 32'd10 << 3);
        rd("R2", {2'd0, 3'd1}, 32'h200);
        wr(2'd0, 3'd0, 32'h1000_0000);
        rd("R2", {2'd0, 3'd0}, 32'h1000_0000);
        wr(2'd0, 3'd4, 32'h0);
        rd("R3", {2'd0, 3'd5}, 32'd0);

        // R4 ownership of pointers
        wr(2'd0, 3'd2, 32'd5 << 5);
        rd("R4", {2'd0, 3'd2}, 32'hA0);
        wr(2'd0, 3'd3, 32'd3 << 5);
        rd("R4", {2'd0, 3'd3}, 32'h0);

        // R6 gate off blocks step, gate bit 2 enables ring 0
        step(1'b0, 5'd0, 32'd0, 4'h1);
        rd("R6", {2'd0, 3'd3}, 32'h0);
        wr(2'd0, 3'd7, 32'h4);
        step(1'b0, 5'd0, 32'd0, 4'h1);
        rd("R6", {2'd0, 3'd3}, 32'h20);
        chk("R8", "ring0 addr", 64'(hw_desc_addr[0 +: AW]), 64'h1000_0020);

        // R7 consumer drains to empty then ignores
        for (int i = 0; i < 6; i++) step(1'b0, 5'd0, 32'd0, 4'h1);
        rd("R7", {2'd0, 3'd3}, 32'hA0);

        // R5 wrap on a two-entry transmit request ring
        wr(2'd2, 3'd4, 32'h6);
        wr(2'd2, 3'd1, 32'd2 << 3);
        wr(2'd2, 3'd0, 32'h2000_0000);
        wr(2'd0, 3'd7, 32'h7);
        wr(2'd2, 3'd2, 32'd1 << 5);
        step(1'b0, 5'd0, 32'd0, 4'h4);
        wr(2'd2, 3'd2, 32'd0);
        step(1'b0, 5'd0, 32'd0, 4'h4);
        rd("R5", {2'd2, 3'd3}, 32'h0);

        // R7 producer fills a two-entry completion ring
        wr(2'd3, 3'd4, 32'h2);
        wr(2'd3, 3'd1, 32'd2 << 3);
        wr(2'd0, 3'd7, 32'hF);
        step(1'b0, 5'd0, 32'd0, 4'h8);
        chk("R7", "tx done full", 64'(hw_full[3]), 64'h1);
        step(1'b0, 5'd0, 32'd0, 4'h8);
        rd("R7", {2'd3, 3'd2}, 32'h20);
        // R5 depth zero ring never steps
        step(1'b0, 5'd0, 32'd0, 4'h2);
        rd("R5", {2'd1, 3'd2}, 32'h0);

        // receive rings at 64 entries, then random traffic
        wr(2'd1, 3'd4, 32'h6);
        wr(2'd1, 3'd1, 32'd64 << 3);
        wr(2'd1, 3'd0, 32'h3000_0000);
        for (int i = 0; i < 3000; i++) begin
            int op;
            int q;
            logic [31:0] d;
            op = int'($urandom % 10);
            q  = int'($urandom % 4);
            d  = $urandom;
            if (op < 6)
                step(1'b0, {q[1:0], 3'd2}, 32'd0, 4'($urandom));
            else if (op < 8)
                step(1'b1, {q[1:0], prod[q] ? 3'd3 : 3'd2},
                     {20'd0, 7'(d % (m_dep[q] == 0 ? 1 : m_dep[q])), 5'd0}, 4'($urandom));
            else if (op == 8)
                step(1'b1, {q[1:0], 3'd7}, {28'd0, 4'($urandom)}, 4'($urandom));
            else
                step(1'b1, {q[1:0], 3'($urandom % 5)}, d & 32'hFFFF_FFE0, 4'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule